// File: doc/BRIEF.md
# Multi-width aliased general register file

This block holds sixteen 64-bit general registers that can be written and read at five widths: the low byte, the second byte (bits 15:8), the low 16 bits, the low 32 bits and the full 64 bits. Each write merges into the stored value by a fixed rule. Wider writes replace everything. A 32-bit write clears the upper half. Writes of 16 bits or a single byte keep every bit outside the written field.

There is one write port, which updates the array on the rising clock edge. There are also two read ports with no register on the path. Each port carries an index, a two-bit size code and a high-byte select. A read returns the chosen field shifted down to bit 0 and zero-extended to 64 bits.

The high-byte form is only valid on indices 0 to 3. A request for it on any other index is flagged as illegal on that port. An illegal write changes nothing, and an illegal read returns zero.

Top module: `gpr_file`

## Requirements
- R1: A write with size code 2'b11 (64-bit) replaces all 64 bits of the indexed register with wr_data.
- R2: A write with size code 2'b10 (32-bit) stores wr_data[31:0] in bits 31:0 and forces bits 63:32 to zero. For example, 0x1111111111111111 at 64 bits followed by 0x22222222 at 32 bits leaves 0x0000000022222222.
- R3: A write with size code 2'b01 (16-bit) replaces bits 15:0 only and keeps bits 63:16.
- R4: A write with size code 2'b00 (byte) and wr_hi low replaces bits 7:0 only. It is legal on all sixteen indices.
- R5: A write with size code 2'b00 and wr_hi high, to index 0 to 3, stores wr_data[7:0] in bits 15:8 and keeps all other bits.
- R6: A port with size code 2'b00, its high-byte select set and an index of 4 or more drives its illegal flag high in the same cycle. On the write port the array is left unchanged. On a read port the data is zero.
- R7: The high-byte select has no effect when the size code is not 2'b00. The access behaves as the plain access of that size and is never flagged.
- R8: Each read port combinationally returns the selected field zero-extended to 64 bits. A high-byte read returns bits 15:8 in bits 7:0.
- R9: A read of the register being written in the same cycle returns the value from before the write. The new value is visible after the clock edge.
- R10: An asynchronous active-low reset clears every register to zero.
- R11: Writing 0xABCDEF12 at 32 bits, then 0x1234 at 16 bits, then 0xAB to the low byte leaves 0xABCD12AB in the low 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write size code (00 byte, 01 16-bit, 10 32-bit, 11 64-bit) |
| wr_hi | input | 1 | Write targets bits 15:8 (byte size only) |
| wr_data | input | 64 | Write data, right-aligned |
| wr_bad | output | 1 | Write request is illegal and suppressed |
| ra_idx | input | 4 | Read port A index |
| ra_size | input | 2 | Read port A size code |
| ra_hi | input | 1 | Read port A high-byte select |
| ra_data | output | 64 | Read port A data, zero-extended |
| ra_bad | output | 1 | Read port A request is illegal |
| rb_idx | input | 4 | Read port B index |
| rb_size | input | 2 | Read port B size code |
| rb_hi | input | 1 | Read port B high-byte select |
| rb_data | output | 64 | Read port B data, zero-extended |
| rb_bad | output | 1 | Read port B request is illegal |

## Verification
The bench targets the merge boundaries of the write widths:
- A design that sign- or zero-extends a 16-bit or byte write would destroy the upper bits.
- A design that merges a 32-bit write would leave stale data in bits 63:32.

Both faults are caught by the two fixed write sequences and by a reference model over thousands of random mixed-width writes.

High-byte requests on indices 4 to 15 are aimed at the window check. A design that drops that check would corrupt bits 15:8 of registers such as 5. A design that applies the select to other sizes would mis-place 16-bit data.

Reads of the register being written in the same cycle expose a design that bypasses the write data to the read ports.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  localparam int unsigned GPR_XLEN   = 64;
  localparam int unsigned GPR_NREG   = 16;
  localparam int unsigned GPR_NHIREG = 4;

  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_W = 2'b01,
    SZ_D = 2'b10,
    SZ_Q = 2'b11
  } acc_size_e;

endpackage

// File: rtl/gpr_access_check.sv
// Decides whether one access is legal and whether it targets the second byte.
module gpr_access_check
  import gpr_pkg::*;
#(
  parameter int unsigned NREG   = GPR_NREG,
  parameter int unsigned NHIREG = GPR_NHIREG,
  localparam int unsigned IDXW  = $clog2(NREG)
) (
  input  logic [IDXW-1:0] idx,
  input  acc_size_e       size,
  input  logic            hi,
  output logic            hi_sel,
  output logic            legal
);

  localparam logic [IDXW:0] HI_LIMIT = (IDXW+1)'(NHIREG);

  always_comb begin
    hi_sel = hi && (size == SZ_B);
    legal  = !hi_sel || ({1'b0, idx} < HI_LIMIT);
  end

endmodule

// File: rtl/gpr_merge.sv
// Combines new write data with the old register contents by access width.
module gpr_merge
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN = GPR_XLEN,
  localparam int unsigned BW  = XLEN / 8,
  localparam int unsigned WW  = XLEN / 4,
  localparam int unsigned DW  = XLEN / 2
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] data,
  input  acc_size_e       size,
  input  logic            hi_sel,
  output logic [XLEN-1:0] new_val
);

  always_comb begin
    new_val = old_val;
    unique case (size)
      SZ_Q: new_val = data;
      SZ_D: new_val = {{(XLEN-DW){1'b0}}, data[DW-1:0]};
      SZ_W: new_val = {old_val[XLEN-1:WW], data[WW-1:0]};
      SZ_B: begin
        if (hi_sel) begin
          new_val = {old_val[XLEN-1:WW], data[BW-1:0], old_val[BW-1:0]};
        end else begin
          new_val = {old_val[XLEN-1:BW], data[BW-1:0]};
        end
      end
      default: new_val = old_val;
    endcase
  end

endmodule

// File: rtl/gpr_extract.sv
// Picks the requested field out of a register and zero-extends it.
module gpr_extract
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN = GPR_XLEN,
  localparam int unsigned BW  = XLEN / 8,
  localparam int unsigned WW  = XLEN / 4,
  localparam int unsigned DW  = XLEN / 2
) (
  input  logic [XLEN-1:0] val,
  input  acc_size_e       size,
  input  logic            hi_sel,
  input  logic            legal,
  output logic [XLEN-1:0] out
);

  always_comb begin
    out = '0;
    if (legal) begin
      unique case (size)
        SZ_Q: out = val;
        SZ_D: out = {{(XLEN-DW){1'b0}}, val[DW-1:0]};
        SZ_W: out = {{(XLEN-WW){1'b0}}, val[WW-1:0]};
        SZ_B: begin
          if (hi_sel) begin
            out = {{(XLEN-BW){1'b0}}, val[WW-1:BW]};
          end else begin
            out = {{(XLEN-BW){1'b0}}, val[BW-1:0]};
          end
        end
        default: out = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpr_file.sv
// Sixteen aliased registers with one write port and two combinational read ports.
module gpr_file
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN   = GPR_XLEN,
  parameter int unsigned NREG   = GPR_NREG,
  parameter int unsigned NHIREG = GPR_NHIREG,
  localparam int unsigned IDXW  = $clog2(NREG),
  localparam int unsigned NRD   = 2,
  localparam int unsigned BW    = XLEN / 8,
  localparam int unsigned WW    = XLEN / 4,
  localparam int unsigned DW    = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [1:0]      wr_size,
  input  logic            wr_hi,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_bad,
  input  logic [IDXW-1:0] ra_idx,
  input  logic [1:0]      ra_size,
  input  logic            ra_hi,
  output logic [XLEN-1:0] ra_data,
  output logic            ra_bad,
  input  logic [IDXW-1:0] rb_idx,
  input  logic [1:0]      rb_size,
  input  logic            rb_hi,
  output logic [XLEN-1:0] rb_data,
  output logic            rb_bad
);

  logic [XLEN-1:0] regs [NREG];

  // ---------------- write path ----------------
  acc_size_e       wr_sz;
  logic            wr_hisel;
  logic            wr_legal;
  logic [XLEN-1:0] wr_old;
  logic [XLEN-1:0] wr_merged;
  logic [NREG-1:0] reg_we;

  assign wr_sz  = acc_size_e'(wr_size);
  assign wr_old = regs[wr_idx];
  assign wr_bad = !wr_legal;

  gpr_access_check #(.NREG(NREG), .NHIREG(NHIREG)) u_wr_chk (
    .idx    (wr_idx),
    .size   (wr_sz),
    .hi     (wr_hi),
    .hi_sel (wr_hisel),
    .legal  (wr_legal)
  );

  gpr_merge #(.XLEN(XLEN)) u_wr_merge (
    .old_val (wr_old),
    .data    (wr_data),
    .size    (wr_sz),
    .hi_sel  (wr_hisel),
    .new_val (wr_merged)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [XLEN-1:0] nxt;

    always_comb begin
      reg_we[i] = wr_en && wr_legal && (wr_idx == IDXW'(i));
      nxt       = wr_merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (reg_we[i]) begin
        regs[i] <= nxt;
      end
    end

    a_r1_qword_full: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we[i] && wr_sz == SZ_Q) |=> regs[i] == $past(wr_data));

    a_r2_dword_zext: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we[i] && wr_sz == SZ_D) |=>
        (regs[i][XLEN-1:DW] == '0) && (regs[i][DW-1:0] == $past(wr_data[DW-1:0])));

    a_r3_word_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we[i] && wr_sz == SZ_W) |=>
        (regs[i][XLEN-1:WW] == $past(regs[i][XLEN-1:WW])) &&
        (regs[i][WW-1:0] == $past(wr_data[WW-1:0])));

    a_r4_low_byte_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we[i] && wr_sz == SZ_B && !wr_hi) |=>
        regs[i][XLEN-1:BW] == $past(regs[i][XLEN-1:BW]));

    a_r5_high_byte_place: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we[i] && wr_sz == SZ_B && wr_hi) |=>
        (regs[i][BW-1:0] == $past(regs[i][BW-1:0])) &&
        (regs[i][WW-1:BW] == $past(wr_data[BW-1:0])) &&
        (regs[i][XLEN-1:WW] == $past(regs[i][XLEN-1:WW])));

    a_r6_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_bad) |=> regs[i] == $past(regs[i]));
  end

  a_r6_hi_window: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bad) |-> (wr_hi && wr_sz == SZ_B && wr_idx >= IDXW'(NHIREG)));

  a_r7_wide_never_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sz != SZ_B) |-> !wr_bad);

  // ---------------- read paths ----------------
  logic [IDXW-1:0] rd_idx   [NRD];
  acc_size_e       rd_sz    [NRD];
  logic            rd_hi    [NRD];
  logic [XLEN-1:0] rd_data  [NRD];
  logic            rd_legal [NRD];

  always_comb begin
    rd_idx[0] = ra_idx;
    rd_sz[0]  = acc_size_e'(ra_size);
    rd_hi[0]  = ra_hi;
    rd_idx[1] = rb_idx;
    rd_sz[1]  = acc_size_e'(rb_size);
    rd_hi[1]  = rb_hi;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic hisel;

    gpr_access_check #(.NREG(NREG), .NHIREG(NHIREG)) u_chk (
      .idx    (rd_idx[p]),
      .size   (rd_sz[p]),
      .hi     (rd_hi[p]),
      .hi_sel (hisel),
      .legal  (rd_legal[p])
    );

    gpr_extract #(.XLEN(XLEN)) u_ext (
      .val    (regs[rd_idx[p]]),
      .size   (rd_sz[p]),
      .hi_sel (hisel),
      .legal  (rd_legal[p]),
      .out    (rd_data[p])
    );

    a_r6_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_legal[p] |-> rd_data[p] == '0);
  end

  assign ra_data = rd_data[0];
  assign ra_bad  = !rd_legal[0];
  assign rb_data = rd_data[1];
  assign rb_bad  = !rd_legal[1];

endmodule

// File: tb/tb_gpr_file.sv
`timescale 1ns/1ps
module tb_gpr_file;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [1:0]  wr_size;
  logic        wr_hi;
  logic [63:0] wr_data;
  logic        wr_bad;
  logic [3:0]  ra_idx;
  logic [1:0]  ra_size;
  logic        ra_hi;
  logic [63:0] ra_data;
  logic        ra_bad;
  logic [3:0]  rb_idx;
  logic [1:0]  rb_size;
  logic        rb_hi;
  logic [63:0] rb_data;
  logic        rb_bad;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  logic [63:0] model [16];

  gpr_file dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit legal_m(logic [3:0] idx, logic [1:0] sz, logic hi);
    return !(hi && sz == 2'b00 && idx >= 4);
  endfunction

  function automatic logic [63:0] merge_m(logic [63:0] o, logic [63:0] d,
                                          logic [1:0] sz, logic hi);
    logic [63:0] r;
    r = o;
    case (sz)
      2'b11: r = d;
      2'b10: r = {32'h0, d[31:0]};
      2'b01: r[15:0] = d[15:0];
      default: if (hi) r[15:8] = d[7:0]; else r[7:0] = d[7:0];
    endcase
    return r;
  endfunction

  function automatic logic [63:0] extract_m(logic [63:0] v, logic [1:0] sz, logic hi);
    case (sz)
      2'b11: return v;
      2'b10: return {32'h0, v[31:0]};
      2'b01: return {48'h0, v[15:0]};
      default: return hi ? {56'h0, v[15:8]} : {56'h0, v[7:0]};
    endcase
  endfunction

  task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check reads before the rising edge,
  // then update the model on the rising edge.
  task automatic step(string req, logic we, logic [3:0] wi, logic [1:0] ws,
                      logic wh, logic [63:0] wd,
                      logic [3:0] ai, logic [1:0] as, logic ah,
                      logic [3:0] bi, logic [1:0] bs, logic bh);
    bit la, lb, lw;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_size = ws; wr_hi = wh; wr_data = wd;
    ra_idx = ai; ra_size = as; ra_hi = ah;
    rb_idx = bi; rb_size = bs; rb_hi = bh;
    #1;
    la = legal_m(ai, as, ah);
    lb = legal_m(bi, bs, bh);
    lw = legal_m(wi, ws, wh);
    chk64({req, " R8 port A data"}, ra_data, la ? extract_m(model[ai], as, ah) : 64'h0);
    chk64({req, " R8 port B data"}, rb_data, lb ? extract_m(model[bi], bs, bh) : 64'h0);
    chk1({req, " R6 port A flag"}, ra_bad, !la);
    chk1({req, " R6 write flag"}, wr_bad, !lw);
    @(posedge clk);
    if (we && lw) model[wi] = merge_m(model[wi], wd, ws, wh);
  endtask

  task automatic wr(string req, logic [3:0] i, logic [1:0] s, logic h, logic [63:0] d);
    step(req, 1'b1, i, s, h, d, i, 2'b11, 1'b0, 4'd0, 2'b11, 1'b0);
  endtask

  task automatic rd_q(string req, logic [3:0] i, logic [63:0] exp);
    step(req, 1'b0, 4'd0, 2'b11, 1'b0, 64'h0, i, 2'b11, 1'b0, i, 2'b10, 1'b0);
    chk64(req, ra_data, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_hi = 1'b0; wr_data = '0;
    ra_idx = '0; ra_size = '0; ra_hi = 1'b0; rb_idx = '0; rb_size = '0; rb_hi = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = 64'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: everything reads zero after reset
    for (int i = 0; i < 16; i++) rd_q("R10 reset zero", 4'(i), 64'h0);

    // R11: mixed-width merge sequence on register 0
    wr("R1", 4'd0, 2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr("R2", 4'd0, 2'b10, 1'b0, 64'h0000_0000_ABCD_EF12);
    wr("R3", 4'd0, 2'b01, 1'b0, 64'h0000_0000_0000_1234);
    wr("R4", 4'd0, 2'b00, 1'b0, 64'h0000_0000_0000_00AB);
    rd_q("R11 merge sequence", 4'd0, 64'h0000_0000_ABCD_12AB);

    // R2: 32-bit write clears the upper half of register 9
    wr("R1", 4'd9, 2'b11, 1'b0, 64'h1111_1111_1111_1111);
    wr("R2", 4'd9, 2'b10, 1'b0, 64'hFFFF_FFFF_2222_2222);
    rd_q("R2 zero extend", 4'd9, 64'h0000_0000_2222_2222);

    // R5: high-byte write on register 2, then high-byte read
    wr("R1", 4'd2, 2'b11, 1'b0, 64'h0102_0304_0506_0708);
    wr("R5", 4'd2, 2'b00, 1'b1, 64'h0000_0000_0000_00EE);
    rd_q("R5 high byte write", 4'd2, 64'h0102_0304_0506_EE08);
    step("R8 high read", 1'b0, 4'd0, 2'b11, 1'b0, 64'h0, 4'd2, 2'b00, 1'b1, 4'd2, 2'b00, 1'b0);
    chk64("R8 high byte read", ra_data, 64'h0000_0000_0000_00EE);
    chk64("R8 low byte read", rb_data, 64'h0000_0000_0000_0008);

    // R6: high-byte request on register 5 is flagged and suppressed
    wr("R1", 4'd5, 2'b11, 1'b0, 64'hA5A5_A5A5_A5A5_A5A5);
    wr("R6 illegal write", 4'd5, 2'b00, 1'b1, 64'h0000_0000_0000_0055);
    rd_q("R6 illegal write suppressed", 4'd5, 64'hA5A5_A5A5_A5A5_A5A5);
    step("R6 illegal read", 1'b0, 4'd0, 2'b11, 1'b0, 64'h0, 4'd7, 2'b00, 1'b1, 4'd15, 2'b00, 1'b1);
    chk1("R6 port B flag", rb_bad, 1'b1);
    chk64("R6 port B zero", rb_data, 64'h0);

    // R4: low byte legal on register 6
    wr("R4 low byte idx6", 4'd6, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FF3C);
    rd_q("R4 low byte idx6", 4'd6, 64'h0000_0000_0000_003C);

    // R7: high select ignored with a 16-bit size on register 12
    wr("R1", 4'd12, 2'b11, 1'b0, 64'h8877_6655_4433_2211);
    wr("R7 hi ignored", 4'd12, 2'b01, 1'b1, 64'h0000_0000_0000_BEEF);
    rd_q("R7 hi ignored", 4'd12, 64'h8877_6655_4433_BEEF);

    // R9: same-cycle read returns old value, new value after the edge
    wr("R1", 4'd3, 2'b11, 1'b0, 64'h0000_0000_0000_1000);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd3; wr_size = 2'b11; wr_hi = 1'b0; wr_data = 64'hCAFE_0000_0000_0001;
    ra_idx = 4'd3; ra_size = 2'b11; ra_hi = 1'b0;
    #1;
    chk64("R9 old value before edge", ra_data, 64'h0000_0000_0000_1000);
    @(posedge clk);
    model[3] = 64'hCAFE_0000_0000_0001;
    #1;
    chk64("R9 new value after edge", ra_data, 64'hCAFE_0000_0000_0001);

    // Random mixed traffic against the model (R1-style merges of all widths)
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] ws;
      logic [3:0] wi;
      ws = 2'($urandom_range(0, 3));
      wi = 4'($urandom_range(0, 15));
      step("R8 random", ($urandom_range(0, 3) != 0), wi, ws, ($urandom_range(0, 3) == 0),
           {$urandom, $urandom},
           4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 1) == 0) ? wi : 4'($urandom_range(0, 15)),
           2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0));
    end

    for (int i = 0; i < 16; i++) rd_q("R1 final contents", 4'(i), model[i]);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule